// File: doc/BRIEF.md
# Consecutive Protection Event Supervisor

This block watches two protection comparator outputs of a switching power stage and decides when the stage must stop switching. The first input is a heavy-overcurrent flag. It is meaningful only while the power switch is on, and only after a short blanking interval that follows each turn-on. The second input is an overvoltage flag. It is meaningful only while the switch is off, and only after a longer blanking interval that follows each turn-off.

Each flag has its own counter, which counts at most one event per gate phase. A phase in which the flag did not fire resets that counter to zero, so only unbroken runs of events count. When either counter reaches its limit, the block enters fault mode and raises a switching inhibit. The cause of the fault is recorded. A static strap selects how fault mode ends. In timed mode, a restart timer ends fault mode and the counters start again from zero. In latched mode, fault mode holds until reset. A separate output asks the gate-restart watchdog to use its long interval once a heavy-overcurrent event has been seen. That request drops again after the first clean on-time.

The gate controller drives the gate level and single-cycle strobes on each gate edge. Those strobes mark the start and end of each phase. Analog thresholds are handled outside this block.

Top module: `prot_fault_guard`

## Requirements
- R1: After reset, faultActive, switchInhibit, wdExtend and faultCause are all 0.
- R2: ocpFlag is ignored during the first OCP_BLANK_CYC cycles after a gateRise strobe and while gateOn is 0. At most one overcurrent event is counted per on-time.
- R3: EVENT_LIMIT overcurrent events in consecutive on-times enter fault mode during the on-time that holds the last event. faultActive and switchInhibit go to 1, and faultCause goes to 0 (0 means overcurrent).
- R4: An on-time that ends (gateFall) without a counted overcurrent event resets the overcurrent count to zero.
- R5: wdExtend goes to 1 on the cycle after a counted overcurrent event. It returns to 0 when an on-time ends without an event, or when a timed restart occurs.
- R6: ovpFlag is ignored during the first OVP_BLANK_CYC cycles after a gateFall strobe, and while gateOn is 1. At most one overvoltage event is counted per off-time.
- R7: EVENT_LIMIT overvoltage events in consecutive off-times enter fault mode. faultActive and switchInhibit go to 1, and faultCause goes to 1 (1 means overvoltage).
- R8: An off-time that ends (gateRise) without a counted overvoltage event resets the overvoltage count to zero.
- R9: With latchMode at 0, fault mode lasts exactly RESTART_CYC clock cycles. After that, both counts restart from zero, and faultCause keeps its value until the next fault.
- R10: With latchMode at 1, fault mode holds until rstN is asserted. Reset clears the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on / supply reset |
| gateOn | input | 1 | Gate level, 1 while the power switch is on |
| gateRise | input | 1 | Single-cycle strobe on the cycle the gate turns on |
| gateFall | input | 1 | Single-cycle strobe on the cycle the gate turns off |
| ocpFlag | input | 1 | Heavy-overcurrent comparator output |
| ovpFlag | input | 1 | Overvoltage comparator output |
| latchMode | input | 1 | Strap: 1 latches the fault, 0 selects timed restart |
| faultActive | output | 1 | Fault mode is active |
| switchInhibit | output | 1 | Gate controller must not switch |
| wdExtend | output | 1 | Request for the long watchdog restart interval |
| faultCause | output | 1 | Cause of the last fault: 0 overcurrent, 1 overvoltage |

## Verification
Several properties are checked on every cycle. Fault entry always follows a cycle in which one of the flags was high. The recorded cause stays unchanged for the whole fault. A latched fault never releases. A timed fault never outlasts the restart interval. wdExtend rises only after an unblanked on-time sample, and falls only on a gate turn-off or at a restart. Other behaviours can only be shown by the bench scenarios. These are the blanking boundaries, the counting of one event per phase, the reset of a count by a single clean phase in the middle of a run, the exact fault duration, and the clearing of the counts at restart.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic freeze;    // hold counters, ignore flags
    logic runTimer;  // advance the restart timer
    logic clearAll;  // restart: zero the counters and the extend request
  } pfmCtl_t;

  typedef enum logic {
    CAUSE_OCP = 1'b0,
    CAUSE_OVP = 1'b1
  } faultCause_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_FAULT = 1'b1
  } pfmState_e;

endpackage

// File: rtl/pfm_datapath.sv
module pfm_datapath
  import pfm_pkg::*;
#(
  parameter int OCP_BLANK_CYC = 15,
  parameter int OVP_BLANK_CYC = 250,
  parameter int EVENT_LIMIT   = 4,
  parameter int RESTART_CYC   = 125_000_000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    gateOn,
  input  logic    gateRise,
  input  logic    gateFall,
  input  logic    ocpFlag,
  input  logic    ovpFlag,
  input  pfmCtl_t ctl,
  output logic    ocpTrip,
  output logic    ovpTrip,
  output logic    restartDone,
  output logic    wdExtend
);

  localparam int NCH       = 2;
  localparam int CH_OCP    = 0;
  localparam int CH_OVP    = 1;
  localparam int MAX_BLANK = (OCP_BLANK_CYC > OVP_BLANK_CYC) ? OCP_BLANK_CYC : OVP_BLANK_CYC;
  localparam int AGE_W     = $clog2(MAX_BLANK + 1);
  localparam int CNT_W     = $clog2(EVENT_LIMIT + 1);
  localparam int TMR_W     = $clog2(RESTART_CYC + 1);

  // per-channel phase view: channel 0 lives in the on-time, channel 1 in the off-time
  logic [NCH-1:0] phaseLvl, phaseBegin, phaseEnd, flagIn, chHit, chTrip;

  assign phaseLvl   = {~gateOn, gateOn};
  assign phaseBegin = {gateFall, gateRise};
  assign phaseEnd   = {gateRise, gateFall};
  assign flagIn     = {ovpFlag, ocpFlag};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam int BLANK = (ch == CH_OCP) ? OCP_BLANK_CYC : OVP_BLANK_CYC;
    localparam logic [AGE_W-1:0] BLANK_AGE = AGE_W'(BLANK);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(EVENT_LIMIT - 1);
    localparam logic [CNT_W-1:0] MAX_CNT   = CNT_W'(EVENT_LIMIT);

    logic [AGE_W-1:0] age;
    logic             seen;
    logic [CNT_W-1:0] count;
    logic             windowOpen;

    assign windowOpen = phaseLvl[ch] && !phaseBegin[ch] && (age != '0) && (age >= BLANK_AGE);
    assign chHit[ch]  = windowOpen && flagIn[ch] && !seen && !ctl.freeze;
    assign chTrip[ch] = chHit[ch] && (count == LAST_CNT);

    // cycles since the phase began, saturating at the blanking length
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  age <= '0;
      else if (phaseBegin[ch])                    age <= AGE_W'(1);
      else if (phaseLvl[ch] && age < BLANK_AGE)   age <= age + 1'b1;
    end

    // one event per phase
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               seen <= 1'b0;
      else if (phaseBegin[ch]) seen <= 1'b0;
      else if (chHit[ch])      seen <= 1'b1;
    end

    // consecutive-event count
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              count <= '0;
      else if (ctl.clearAll)                  count <= '0;
      else if (ctl.freeze)                    count <= count;
      else if (chHit[ch])                     count <= (count < MAX_CNT) ? count + 1'b1 : count;
      else if (phaseEnd[ch] && !seen)         count <= '0;
    end

    if (ch == CH_OCP) begin : g_extend
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          wdExtend <= 1'b0;
        else if (ctl.clearAll)              wdExtend <= 1'b0;
        else if (chHit[ch])                 wdExtend <= 1'b1;
        else if (phaseEnd[ch] && !seen)     wdExtend <= 1'b0;
      end
    end
  end

  assign ocpTrip = chTrip[CH_OCP];
  assign ovpTrip = chTrip[CH_OVP];

  // restart timer, held at zero whenever it is not running
  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tmr <= '0;
    else if (!ctl.runTimer) tmr <= '0;
    else                   tmr <= tmr + 1'b1;
  end

  assign restartDone = (tmr == TMR_W'(RESTART_CYC - 1));

endmodule

// File: rtl/pfm_control.sv
module pfm_control
  import pfm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        latchMode,
  input  logic        ocpTrip,
  input  logic        ovpTrip,
  input  logic        restartDone,
  output pfmCtl_t     ctl,
  output logic        faultActive,
  output faultCause_e faultCause
);

  pfmState_e state;
  logic      inFault;
  logic      timing;
  logic      releaseNow;

  assign inFault    = (state == ST_FAULT);
  assign timing     = inFault && !latchMode;
  assign releaseNow = timing && restartDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RUN;
      faultCause <= CAUSE_OCP;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (ocpTrip) begin
            state      <= ST_FAULT;
            faultCause <= CAUSE_OCP;
          end else if (ovpTrip) begin
            state      <= ST_FAULT;
            faultCause <= CAUSE_OVP;
          end
        end
        ST_FAULT: begin
          if (releaseNow) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    ctl.freeze   = inFault;
    ctl.runTimer = timing;
    ctl.clearAll = releaseNow;
  end

  assign faultActive = inFault;

endmodule

// File: rtl/prot_fault_guard.sv
module prot_fault_guard
  import pfm_pkg::*;
#(
  parameter int OCP_BLANK_CYC = 15,
  parameter int OVP_BLANK_CYC = 250,
  parameter int EVENT_LIMIT   = 4,
  parameter int RESTART_CYC   = 125_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateOn,
  input  logic gateRise,
  input  logic gateFall,
  input  logic ocpFlag,
  input  logic ovpFlag,
  input  logic latchMode,
  output logic faultActive,
  output logic switchInhibit,
  output logic wdExtend,
  output logic faultCause
);

  pfmCtl_t     ctl;
  logic        ocpTrip, ovpTrip, restartDone;
  faultCause_e causeEnum;

  pfm_datapath #(
    .OCP_BLANK_CYC(OCP_BLANK_CYC),
    .OVP_BLANK_CYC(OVP_BLANK_CYC),
    .EVENT_LIMIT  (EVENT_LIMIT),
    .RESTART_CYC  (RESTART_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .gateOn     (gateOn),
    .gateRise   (gateRise),
    .gateFall   (gateFall),
    .ocpFlag    (ocpFlag),
    .ovpFlag    (ovpFlag),
    .ctl        (ctl),
    .ocpTrip    (ocpTrip),
    .ovpTrip    (ovpTrip),
    .restartDone(restartDone),
    .wdExtend   (wdExtend)
  );

  pfm_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .latchMode  (latchMode),
    .ocpTrip    (ocpTrip),
    .ovpTrip    (ovpTrip),
    .restartDone(restartDone),
    .ctl        (ctl),
    .faultActive(faultActive),
    .faultCause (causeEnum)
  );

  assign switchInhibit = faultActive;
  assign faultCause    = causeEnum;

endmodule

// File: rtl/prot_fault_guard_chk.sv
module prot_fault_guard_chk #(
  parameter int RESTART_CYC = 125_000_000
) (
  input logic clk,
  input logic rstN,
  input logic gateOn,
  input logic gateRise,
  input logic gateFall,
  input logic ocpFlag,
  input logic ovpFlag,
  input logic latchMode,
  input logic faultActive,
  input logic wdExtend,
  input logic faultCause
);

  int unsigned faultLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            faultLen <= 0;
    else if (faultActive) faultLen <= faultLen + 1;
    else                  faultLen <= 0;
  end

  // R3 R7
  fault_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultActive) |-> $past(ocpFlag || ovpFlag));

  // R3
  cause_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && $past(faultActive)) |-> $stable(faultCause));

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && latchMode) |=> faultActive);

  // R9
  fault_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && !latchMode) |-> (faultLen < RESTART_CYC));

  // R5
  wd_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdExtend) |-> $past(gateOn && ocpFlag && !gateRise));

  // R5
  wd_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdExtend) |-> $past(gateFall || faultActive));

endmodule

bind prot_fault_guard prot_fault_guard_chk #(.RESTART_CYC(RESTART_CYC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .gateOn     (gateOn),
  .gateRise   (gateRise),
  .gateFall   (gateFall),
  .ocpFlag    (ocpFlag),
  .ovpFlag    (ovpFlag),
  .latchMode  (latchMode),
  .faultActive(faultActive),
  .wdExtend   (wdExtend),
  .faultCause (faultCause)
);

// File: tb/prot_fault_guard_test.sv
module prot_fault_guard_test;

  localparam int OCPB = 15;
  localparam int OVPB = 20;
  localparam int LIM  = 4;
  localparam int RST  = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateOn = 1'b0, gateRise = 1'b0, gateFall = 1'b0;
  logic ocpFlag = 1'b0, ovpFlag = 1'b0, latchMode = 1'b0;
  logic faultActive, switchInhibit, wdExtend, faultCause;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prot_fault_guard #(
    .OCP_BLANK_CYC(OCPB),
    .OVP_BLANK_CYC(OVPB),
    .EVENT_LIMIT  (LIM),
    .RESTART_CYC  (RST)
  ) uut (
    .clk(clk), .rstN(rstN), .gateOn(gateOn), .gateRise(gateRise), .gateFall(gateFall),
    .ocpFlag(ocpFlag), .ovpFlag(ovpFlag), .latchMode(latchMode),
    .faultActive(faultActive), .switchInhibit(switchInhibit),
    .wdExtend(wdExtend), .faultCause(faultCause)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic latch);
    @(negedge clk);
    rstN = 1'b0; gateOn = 0; gateRise = 0; gateFall = 0; ocpFlag = 0; ovpFlag = 0;
    latchMode = latch;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // mode: 0 flag low, 1 flag high for the whole phase, 2 flag high only inside blanking
  task automatic pulse(input int onCyc, input int ocpMode, input int offCyc, input int ovpMode);
    @(negedge clk);
    gateOn = 1; gateRise = 1; ovpFlag = 0; ocpFlag = (ocpMode != 0);
    for (int i = 0; i < onCyc; i++) begin
      @(negedge clk);
      gateRise = 0;
      if (ocpMode == 2 && i >= OCPB - 3) ocpFlag = 0;
    end
    @(negedge clk);
    gateOn = 0; gateFall = 1; ocpFlag = 0; ovpFlag = (ovpMode != 0);
    for (int i = 0; i < offCyc; i++) begin
      @(negedge clk);
      gateFall = 0;
      if (ovpMode == 2 && i >= OVPB - 3) ovpFlag = 0;
    end
    ovpFlag = 0;
  endtask

  task automatic t_reset();
    doReset(1'b0);
    check("R1 faultActive", faultActive, 0);
    check("R1 switchInhibit", switchInhibit, 0);
    check("R1 wdExtend", wdExtend, 0);
    check("R1 faultCause", faultCause, 0);
  endtask

  task automatic t_ocp_blank();
    doReset(1'b0);
    for (int k = 0; k < 5; k++) pulse(30, 2, 40, 0);
    check("R2 early flag ignored fault", faultActive, 0);
    check("R2 early flag ignored wdExtend", wdExtend, 0);
    for (int k = 0; k < 5; k++) pulse(10, 1, 40, 0);
    check("R2 short on-time ignored", faultActive, 0);
    check("R2 short on-time wdExtend", wdExtend, 0);
  endtask

  task automatic t_ocp_trip();
    doReset(1'b0);
    for (int k = 0; k < LIM - 1; k++) pulse(30, 1, 40, 0);
    check("R3 below limit", faultActive, 0);
    pulse(30, 1, 40, 0);
    check("R3 fault entered", faultActive, 1);
    check("R3 inhibit", switchInhibit, 1);
    check("R3 cause overcurrent", faultCause, 0);
  endtask

  task automatic t_ocp_clear();
    doReset(1'b0);
    for (int k = 0; k < LIM - 1; k++) pulse(30, 1, 40, 0);
    pulse(30, 0, 40, 0);
    for (int k = 0; k < LIM - 1; k++) pulse(30, 1, 40, 0);
    check("R4 clean pulse broke run", faultActive, 0);
    pulse(30, 1, 40, 0);
    check("R4 fresh run trips", faultActive, 1);
  endtask

  task automatic t_wd();
    doReset(1'b0);
    pulse(30, 1, 40, 0);
    check("R5 extend set", wdExtend, 1);
    pulse(30, 0, 40, 0);
    check("R5 extend cleared", wdExtend, 0);
  endtask

  task automatic t_ovp_blank();
    doReset(1'b0);
    for (int k = 0; k < 5; k++) pulse(30, 0, 40, 2);
    check("R6 early flag ignored", faultActive, 0);
    for (int k = 0; k < 5; k++) pulse(30, 0, 12, 1);
    check("R6 short off-time ignored", faultActive, 0);
  endtask

  task automatic t_ovp_trip();
    doReset(1'b0);
    for (int k = 0; k < LIM - 1; k++) pulse(30, 0, 40, 1);
    check("R7 below limit", faultActive, 0);
    pulse(30, 0, 40, 1);
    check("R7 fault entered", faultActive, 1);
    check("R7 inhibit", switchInhibit, 1);
    check("R7 cause overvoltage", faultCause, 1);
    check("R7 no extend", wdExtend, 0);
  endtask

  task automatic t_ovp_clear();
    doReset(1'b0);
    for (int k = 0; k < LIM - 1; k++) pulse(30, 0, 40, 1);
    pulse(30, 0, 40, 0);
    for (int k = 0; k < LIM - 1; k++) pulse(30, 0, 40, 1);
    check("R8 clean off-time broke run", faultActive, 0);
  endtask

  // last overvoltage off-time, returning on the first cycle faultActive is seen high
  task automatic ovpUntilFault(output int waited);
    waited = 0;
    @(negedge clk);
    gateOn = 1; gateRise = 1; ovpFlag = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); gateRise = 0; end
    @(negedge clk);
    gateOn = 0; gateFall = 1; ovpFlag = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      gateFall = 0;
      waited++;
      if (faultActive) break;
    end
    ovpFlag = 0;
  endtask

  task automatic t_timed();
    int w;
    int len;
    doReset(1'b0);
    for (int k = 0; k < LIM - 1; k++) pulse(30, 0, 40, 1);
    ovpUntilFault(w);
    check("R9 fault seen", faultActive, 1);
    len = 1;
    for (int i = 0; i < RST + 20; i++) begin
      @(negedge clk);
      if (faultActive) len++; else break;
    end
    check("R9 fault length", len, RST);
    check("R9 cause kept", faultCause, 1);
    for (int k = 0; k < LIM - 1; k++) pulse(30, 0, 40, 1);
    check("R9 count restarted", faultActive, 0);
    pulse(30, 0, 40, 1);
    check("R9 full run trips again", faultActive, 1);
    repeat (RST + 5) @(negedge clk);
    for (int k = 0; k < LIM; k++) pulse(30, 1, 40, 0);
    check("R9 new cause overcurrent", faultCause, 0);
  endtask

  task automatic t_latch();
    doReset(1'b1);
    for (int k = 0; k < LIM; k++) pulse(30, 1, 40, 0);
    check("R10 fault entered", faultActive, 1);
    repeat (RST + 50) @(negedge clk);
    check("R10 still latched", faultActive, 1);
    doReset(1'b1);
    check("R10 reset clears", faultActive, 0);
  endtask

  initial begin
    t_reset();
    t_ocp_blank();
    t_ocp_trip();
    t_ocp_clear();
    t_wd();
    t_ovp_blank();
    t_ovp_trip();
    t_ovp_clear();
    t_timed();
    t_latch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule